// File: doc/BRIEF.md
# Serial Frame Acknowledge Timer

This block sits on the transmit side of a point-to-point serial frame link and judges the receiver's reply to every frame. When the transmitter's valid strobe drops at the end of a frame, the block starts a cycle counter. It then watches the ready line coming back from the receiver on every rising clock edge.

The ready line has two meanings, and the block tells them apart by timing. A rise while the count is still below a programmable window length means the frame arrived clean. A rise after the window has run out means the receiver found a parity error and dropped the frame. If ready never rises before a second programmable limit, the block reports that the receiver did not answer. Any reply at all also shows that the receiver is alive.

Each outcome is a single-cycle pulse. A level flag tells the frame source when a new frame may start. Frame serialisation, parity generation and retry policy belong to other blocks.

Top module: `frame_ack_timer`

## Requirements
- R1: After reset all three outcome pulses are low and `tx_allow_o` is high.
- R2: A falling edge on `valid_i` (high on one clock edge, low on the next) starts an evaluation. The count is 0 right after that edge and rises by one on each later edge. `tx_allow_o` stays low from that edge until an outcome pulse is given.
- R3: `ready_i` is first sampled high at the edge that ends the count-value c, and c is below the latched window length. Then `ack_ok_o` pulses for exactly one cycle after that edge, and `tx_allow_o` is high from the same cycle.
- R4: `ready_i` is first sampled high while c is equal to or above the latched window length. Then `parity_err_o` pulses instead. A window length of 0 classifies every reply as a parity error.
- R5: `ready_i` stays low through the edge that ends the count-value equal to the latched timeout limit. Then `timeout_o` pulses after that edge, the counter stops, and the evaluation ends.
- R6: `delay_len_i` and `timeout_len_i` are captured at the falling edge of `valid_i`. Changes to them during an evaluation have no effect on it.
- R7: Each evaluation produces exactly one pulse. No two pulses are ever high together, and a pulse never lasts more than one cycle.
- R8: While `valid_i` is high during an evaluation, the counter holds and no outcome pulse is produced, whatever `ready_i` does.
- R9: When ready is first seen high at the count equal to the timeout limit, the reply is classified by the window (R3/R4) and not as a timeout.
- R10: Outside an evaluation, `ready_i` has no effect. No pulse is produced and `tx_allow_o` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transmit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Transmitter frame valid strobe |
| ready_i | input | 1 | Ready line returned by the receiver |
| delay_len_i | input | DLY_W | Ready window length in clock periods |
| timeout_len_i | input | CNT_W | No-response limit in clock periods |
| ack_ok_o | output | 1 | One-cycle pulse: clean acknowledge |
| parity_err_o | output | 1 | One-cycle pulse: receiver reported parity error |
| timeout_o | output | 1 | One-cycle pulse: no reply before limit |
| tx_allow_o | output | 1 | High when a new frame may start |

## Verification
A counter that clears or advances at the wrong moment moves the clean/error boundary by one reply cycle. The bench therefore places the ready rise exactly one cycle on each side of the window edge and of the timeout limit, and checks which pulse appears and on which edge. A state machine stuck in the waiting state shows up within one frame: `tx_allow_o` stays low and a second pulse or a missing pulse appears. A window value that is not latched shows up as a misclassified reply once the input is changed in the middle of a frame.

// File: rtl/fat_pkg.sv
package fat_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } fat_state_e;

  typedef enum logic [1:0] {
    OUT_NONE = 2'd0,
    OUT_OK   = 2'd1,
    OUT_PERR = 2'd2,
    OUT_TMO  = 2'd3
  } fat_outcome_e;
endpackage

// File: rtl/fat_fall_det.sv
module fat_fall_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic fall_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  assign fall_o = sig_q & ~sig_i;
endmodule

// File: rtl/fat_counter.sv
module fat_counter #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_o <= '0;
    else if (clr_i)                    cnt_o <= '0;
    else if (en_i && cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
  end

  // R2
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0);
endmodule

// File: rtl/frame_ack_timer.sv
module frame_ack_timer
  import fat_pkg::*;
#(
  parameter int unsigned DLY_W = 8,
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             ready_i,
  input  logic [DLY_W-1:0] delay_len_i,
  input  logic [CNT_W-1:0] timeout_len_i,
  output logic             ack_ok_o,
  output logic             parity_err_o,
  output logic             timeout_o,
  output logic             tx_allow_o
);
  localparam int unsigned PAD_W = CNT_W - DLY_W;

  fat_state_e       state_q, state_d;
  fat_outcome_e     outc_d;
  logic             fall;
  logic             eval_en;
  logic             cnt_en;
  logic [CNT_W-1:0] cnt;
  logic [DLY_W-1:0] dly_q;
  logic [CNT_W-1:0] tmo_q;
  logic [CNT_W-1:0] dly_ext;
  logic             in_window;

  fat_fall_det u_fall (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (valid_i),
    .fall_o (fall)
  );

  fat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (fall),
    .en_i   (cnt_en),
    .cnt_o  (cnt)
  );

  // Limits are frozen for the whole evaluation
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q <= '0;
      tmo_q <= '0;
    end else if (fall) begin
      dly_q <= delay_len_i;
      tmo_q <= timeout_len_i;
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign dly_ext = {{PAD_W{1'b0}}, dly_q};
    end else begin : g_nopad
      assign dly_ext = dly_q[CNT_W-1:0];
    end
  endgenerate

  assign in_window = cnt < dly_ext;
  assign eval_en   = (state_q == ST_WAIT) && !valid_i && !fall;

  always_comb begin
    state_d = state_q;
    outc_d  = OUT_NONE;
    cnt_en  = 1'b0;
    if (fall) begin
      state_d = ST_WAIT;
    end else if (eval_en) begin
      if (ready_i) begin
        outc_d  = in_window ? OUT_OK : OUT_PERR;
        state_d = ST_IDLE;
      end else if (cnt == tmo_q) begin
        outc_d  = OUT_TMO;
        state_d = ST_IDLE;
      end else begin
        cnt_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      ack_ok_o     <= 1'b0;
      parity_err_o <= 1'b0;
      timeout_o    <= 1'b0;
    end else begin
      state_q      <= state_d;
      ack_ok_o     <= (outc_d == OUT_OK);
      parity_err_o <= (outc_d == OUT_PERR);
      timeout_o    <= (outc_d == OUT_TMO);
    end
  end

  assign tx_allow_o = (state_q == ST_IDLE);

  // R7
  one_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ack_ok_o, parity_err_o, timeout_o}));
  // R7
  pulse_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_ok_o || parity_err_o || timeout_o) |=> !(ack_ok_o || parity_err_o || timeout_o));
  // R8
  valid_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> !(ack_ok_o || parity_err_o || timeout_o));
  // R3
  ok_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !valid_i && !fall && ready_i && cnt < dly_ext) |=> ack_ok_o && tx_allow_o);
  // R5
  tmo_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> $stable(cnt));
  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !fall) |=> !(ack_ok_o || parity_err_o || timeout_o));
endmodule

// File: tb/frame_ack_timer_bench.sv
`timescale 1ns/1ps
module frame_ack_timer_bench;
  localparam int DLY_W = 8;
  localparam int CNT_W = 10;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             valid_i = 1'b0;
  logic             ready_i = 1'b0;
  logic [DLY_W-1:0] delay_len_i = '0;
  logic [CNT_W-1:0] timeout_len_i = '0;
  logic             ack_ok_o, parity_err_o, timeout_o, tx_allow_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  frame_ack_timer #(.DLY_W(DLY_W), .CNT_W(CNT_W)) u_frame_ack_timer (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .ready_i(ready_i),
    .delay_len_i(delay_len_i), .timeout_len_i(timeout_len_i),
    .ack_ok_o(ack_ok_o), .parity_err_o(parity_err_o),
    .timeout_o(timeout_o), .tx_allow_o(tx_allow_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pulses();
    return {29'd0, ack_ok_o, parity_err_o, timeout_o};
  endfunction

  // Sends one frame, raises ready so that it is first sampled at count m
  // (m<0: never), optionally alters the inputs mid-frame.
  task automatic frame(input string req, input int d, input int t, input int m,
                       input int d_late);
    int exp_kind, n_out, bad_t, bad_a;
    @(negedge clk); valid_i = 1'b1; ready_i = 1'b0;
    repeat (3) @(negedge clk);
    valid_i = 1'b0; delay_len_i = d[DLY_W-1:0]; timeout_len_i = t[CNT_W-1:0];
    @(posedge clk);
    if (m >= 0 && m <= t) begin
      n_out = m + 1; exp_kind = (m < d) ? 4 : 2;
    end else begin
      n_out = t + 1; exp_kind = 1;
    end
    bad_t = 0; bad_a = 0;
    for (int n = 1; n <= n_out + 2; n++) begin
      @(negedge clk);
      if (n == 1 && d_late >= 0) begin
        delay_len_i = d_late[DLY_W-1:0]; timeout_len_i = '1;
      end
      if (m >= 0 && n - 1 == m) ready_i = 1'b1;
      @(posedge clk); #1;
      if (pulses() != ((n == n_out) ? exp_kind : 0)) begin
        bad_t++;
        $display("FAIL %s edge %0d pulses actual=%0d expected=%0d", req, n,
                 pulses(), (n == n_out) ? exp_kind : 0);
      end
      if (tx_allow_o != (n >= n_out)) bad_a++;
    end
    check({req, " pulse timing"}, bad_t, 0);
    check("R2 tx_allow window", bad_a, 0);
    @(negedge clk); ready_i = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 pulses", pulses(), 0);
    check("R1 tx_allow", tx_allow_o, 1);
  endtask

  task automatic t_idle_ready();
    int seen = 0, lowa = 0;
    @(negedge clk); ready_i = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1;
      if (pulses() != 0) seen++;
      if (!tx_allow_o) lowa++;
    end
    @(negedge clk); ready_i = 1'b0;
    check("R10 idle pulses", seen, 0);
    check("R10 idle tx_allow", lowa, 0);
  endtask

  task automatic t_valid_hold();
    int seen = 0;
    // Begin an evaluation, then raise valid with ready high
    @(negedge clk); valid_i = 1'b1;
    @(negedge clk); valid_i = 1'b0; delay_len_i = 8'd3; timeout_len_i = 10'd20;
    @(negedge clk);
    @(negedge clk); valid_i = 1'b1; ready_i = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); #1;
      if (pulses() != 0) seen++;
    end
    check("R8 no outcome while valid", seen, 0);
    check("R8 still waiting", tx_allow_o, 0);
    @(negedge clk); ready_i = 1'b0;
    // Restarted evaluation: clean reply at count 2 with window 4
    frame("R8 restart", 4, 20, 2, -1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_idle_ready();
    frame("R3 ok early", 5, 30, 0, -1);
    frame("R3 ok last", 5, 30, 4, -1);
    frame("R4 perr first", 5, 30, 5, -1);
    frame("R4 perr late", 5, 30, 12, -1);
    frame("R4 zero window", 0, 30, 0, -1);
    frame("R5 timeout", 5, 9, -1, -1);
    frame("R5 tmo just past", 3, 6, 7, -1);
    frame("R9 ready at limit", 8, 6, 6, -1);
    frame("R9 ready at limit perr", 2, 6, 6, -1);
    frame("R6 latched window", 2, 30, 4, 200);
    frame("R6 latched window ok", 10, 30, 7, 1);
    frame("R6 latched timeout", 3, 5, -1, 0);
    frame("R7 back to back", 4, 15, 1, -1);
    t_valid_hold();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule